// File: doc/BRIEF.md
# FG Speed Discriminator with Lock Protection

This block closes the digital half of a motor speed loop. It times the tachometer square wave (FG) in system clock cycles, using two counters that take turns: one times the current period while the other holds the period that just ended. Each completed period is compared against a target count. The block then issues one charge or discharge request for an external loop filter, with a width equal to the count error. A second path compares the phase of FG/2 against a reference signal and adds its own charge or discharge requests. This path is active only while the speed is inside a ±6% window.

A ready flag reports that the last measured period is inside the window. A lock guard counts ticks of a slow external timer while ready is low. When the count runs out, the guard latches a fault that silences every output. The fault latch is cleared only when the controller is stopped or braked. Stop and brake force a discharge request. A fresh start forces a charge request until the first period has been measured.

Top module: `fg_speed_disc`

## Requirements
- R1: The period is the number of clock cycles between successive FG rising edges. Two counters alternate so that each counts one full period. The first rising edge after activation only arms the measurement and produces no result.
- R2: At each completed period of N cycles, with target T = 1024, chg_o pulses for min(N−T, 255) cycles if N > T and dis_o pulses for min(T−N, 255) cycles if N < T. Nothing is emitted when N = T. The pulse starts on the clock edge that detects the closing FG rise.
- R3: ready_o is high after a capture exactly when |N−T| ≤ 61 (T×61/1024). It drops before the next capture as soon as the running count exceeds T+61.
- R4: FG/2 starts low at activation and toggles on every FG rising edge. If a reference rise comes d cycles before an FG/2 rise, chg_o is high for d cycles. If the FG/2 rise comes d cycles before the reference rise, dis_o is high for d cycles. Rises on the same edge give no request.
- R5: While ready_o is low, the phase path contributes nothing to chg_o or dis_o.
- R6: chg_o and dis_o are never high together. An active speed pulse overrides an opposing phase request.
- R7: Stop (run_i low) or brake (run_i high with brake_i high) drives dis_o high and chg_o and ready_o low.
- R8: After activation, chg_o stays high until the first period is completed.
- R9: While the block runs with ready_o low, each lock_tick_i pulse counts. The 32nd consecutive tick (2^5) sets lock_fault_o. A high ready_o clears the count.
- R10: While lock_fault_o is set and the block runs, chg_o, dis_o and ready_o are low. The fault holds through any FG activity and clears on the first clock edge in stop or brake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fg_i | input | 1 | Tachometer square wave, synchronous to clk_i |
| ref_i | input | 1 | Phase reference, rising edge significant |
| run_i | input | 1 | High to run, low to stop |
| brake_i | input | 1 | High to brake while running |
| lock_tick_i | input | 1 | One-cycle pulse from the slow lock timer |
| chg_o | output | 1 | Charge request to the loop filter |
| dis_o | output | 1 | Discharge request to the loop filter |
| ready_o | output | 1 | Speed inside the ±6% window |
| lock_fault_o | output | 1 | Latched lock-protection fault |

## Verification
The hardest states to reach from the ports are the phase-comparator states. They exist only while ready_o is high, and their outcome depends on which of two rising edges arrives first. The bench tracks the FG/2 parity itself. It places reference pulses at chosen cycle offsets before or after an FG/2 rise, and it pairs one such offset with an in-window speed error of the opposite sign to show that the speed pulse takes priority. The lock fault needs a stalled FG followed by exactly 32 ticks. A second sequence lets ready recover halfway through the ticks, which shows that the count restarts.

// File: rtl/fgsd_pkg.sv
package fgsd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_REF_LEAD = 2'd1,
    PH_FG_LEAD  = 2'd2
  } ph_state_e;
endpackage

// File: rtl/fgsd_period_meas.sv
module fgsd_period_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             fg_i,
  output logic             cap_o,
  output logic [CNT_W-1:0] cap_cnt_o,
  output logic [CNT_W-1:0] live_cnt_o,
  output logic             fgh_rise_o,
  output logic             have_meas_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic fg_q, armed_q, sel_q, fg_half_q, have_q;
  logic rise;
  logic [CNT_W-1:0] cnt_w [2];

  assign rise = fg_i & ~fg_q & active_i;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    localparam logic IDX = 1'(g);
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       c_q <= '0;
      else if (!active_i)                c_q <= '0;
      else if (rise) begin
        if (sel_q != IDX)                c_q <= CNT_ONE;
      end
      else if (sel_q == IDX && c_q != CNT_MAX) c_q <= c_q + CNT_ONE;
    end
    assign cnt_w[g] = c_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fg_q <= 1'b0; armed_q <= 1'b0; sel_q <= 1'b0;
      fg_half_q <= 1'b0; have_q <= 1'b0;
    end else begin
      fg_q <= fg_i;
      if (!active_i) begin
        armed_q <= 1'b0; sel_q <= 1'b0; fg_half_q <= 1'b0; have_q <= 1'b0;
      end else if (rise) begin
        armed_q   <= 1'b1;
        sel_q     <= ~sel_q;
        fg_half_q <= ~fg_half_q;
        if (armed_q) have_q <= 1'b1;
      end
    end
  end

  assign live_cnt_o  = cnt_w[sel_q];
  assign cap_cnt_o   = live_cnt_o;
  assign cap_o       = rise & armed_q;
  assign fgh_rise_o  = rise & ~fg_half_q;
  assign have_meas_o = have_q;

  AST_RESTART_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> live_cnt_o == CNT_ONE); // R1
  AST_FIRST_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> $past(active_i)); // R1
endmodule

// File: rtl/fgsd_speed_disc.sv
module fgsd_speed_disc #(
  parameter int CNT_W      = 16,
  parameter int TARGET_CNT = 1024,
  parameter int PW_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cap_cnt_i,
  input  logic [CNT_W-1:0] live_cnt_i,
  output logic             spd_chg_o,
  output logic             spd_dis_o,
  output logic             ready_o
);
  localparam int WIN = TARGET_CNT * 61 / 1024;
  localparam logic [CNT_W-1:0] TGT    = CNT_W'(TARGET_CNT);
  localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(TARGET_CNT + WIN);
  localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(TARGET_CNT - WIN);
  localparam logic [CNT_W-1:0] PW_CAP = CNT_W'((1 << PW_W) - 1);

  logic            slow;
  logic [CNT_W-1:0] mag;
  logic [PW_W-1:0] pw_next, pw_q;
  logic            dir_q, rdy_q, in_win;

  always_comb begin
    slow    = cap_cnt_i > TGT;
    mag     = slow ? cap_cnt_i - TGT : TGT - cap_cnt_i;
    pw_next = (mag > PW_CAP) ? {PW_W{1'b1}} : mag[PW_W-1:0];
    in_win  = (cap_cnt_i >= WIN_LO) && (cap_cnt_i <= WIN_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q <= '0; dir_q <= 1'b0; rdy_q <= 1'b0;
    end else if (!active_i) begin
      pw_q <= '0; dir_q <= 1'b0; rdy_q <= 1'b0;
    end else if (cap_i) begin
      pw_q  <= pw_next;
      dir_q <= slow;
      rdy_q <= in_win;
    end else begin
      if (pw_q != '0) pw_q <= pw_q - PW_W'(1);
      if (live_cnt_i > WIN_HI) rdy_q <= 1'b0;  // stalled FG: too slow already
    end
  end

  assign spd_chg_o = (pw_q != '0) & dir_q;
  assign spd_dis_o = (pw_q != '0) & ~dir_q;
  assign ready_o   = rdy_q;

  AST_READY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && active_i && cap_cnt_i > WIN_HI |=> !ready_o); // R3
  AST_PW_DECAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !cap_i && pw_q != '0 |=> pw_q + PW_W'(1) == $past(pw_q)); // R2
endmodule

// File: rtl/fgsd_phase_cmp.sv
module fgsd_phase_cmp
  import fgsd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_win_i,
  input  logic fgh_rise_i,
  input  logic ref_i,
  output logic ph_chg_o,
  output logic ph_dis_o
);
  ph_state_e st_q;
  logic ref_q, ref_rise;

  assign ref_rise = ref_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PH_IDLE; ref_q <= 1'b0;
    end else begin
      ref_q <= ref_i;
      if (!in_win_i) st_q <= PH_IDLE;
      else begin
        unique case (st_q)
          PH_IDLE: begin
            if (ref_rise && !fgh_rise_i)      st_q <= PH_REF_LEAD;
            else if (fgh_rise_i && !ref_rise) st_q <= PH_FG_LEAD;
          end
          PH_REF_LEAD: if (fgh_rise_i) st_q <= PH_IDLE;
          PH_FG_LEAD:  if (ref_rise)   st_q <= PH_IDLE;
          default:     st_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign ph_chg_o = st_q == PH_REF_LEAD;
  assign ph_dis_o = st_q == PH_FG_LEAD;

  AST_PH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win_i |=> st_q == PH_IDLE); // R5
  AST_PH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win_i && ph_chg_o && fgh_rise_i |=> !ph_chg_o); // R4
endmodule

// File: rtl/fgsd_lock_guard.sv
module fgsd_lock_guard #(
  parameter int LOCK_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ready_i,
  input  logic tick_i,
  output logic fault_o
);
  localparam logic [LOCK_W-1:0] LAST = {LOCK_W{1'b1}};

  logic [LOCK_W-1:0] cnt_q;
  logic              fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; fault_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q <= '0; fault_q <= 1'b0;
    end else if (ready_i) begin
      cnt_q <= '0;
    end else if (tick_i && !fault_q) begin
      if (cnt_q == LAST) fault_q <= 1'b1;
      else               cnt_q   <= cnt_q + LOCK_W'(1);
    end
  end

  assign fault_o = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && fault_q |=> fault_q); // R10
  AST_FAULT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !fault_q); // R10
  AST_FAULT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(tick_i) && !$past(ready_i)); // R9
endmodule

// File: rtl/fg_speed_disc.sv
module fg_speed_disc #(
  parameter int CNT_W      = 16,
  parameter int TARGET_CNT = 1024,
  parameter int PW_W       = 8,
  parameter int LOCK_W     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fg_i,
  input  logic ref_i,
  input  logic run_i,
  input  logic brake_i,
  input  logic lock_tick_i,
  output logic chg_o,
  output logic dis_o,
  output logic ready_o,
  output logic lock_fault_o
);
  logic             active;
  logic             cap, fgh_rise, have_meas;
  logic [CNT_W-1:0] cap_cnt, live_cnt;
  logic             spd_chg, spd_dis, spd_rdy;
  logic             ph_chg, ph_dis, fault;

  assign active = run_i & ~brake_i;

  fgsd_period_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i, .rst_ni, .active_i(active), .fg_i,
    .cap_o(cap), .cap_cnt_o(cap_cnt), .live_cnt_o(live_cnt),
    .fgh_rise_o(fgh_rise), .have_meas_o(have_meas)
  );

  fgsd_speed_disc #(.CNT_W(CNT_W), .TARGET_CNT(TARGET_CNT), .PW_W(PW_W)) u_spd (
    .clk_i, .rst_ni, .active_i(active), .cap_i(cap),
    .cap_cnt_i(cap_cnt), .live_cnt_i(live_cnt),
    .spd_chg_o(spd_chg), .spd_dis_o(spd_dis), .ready_o(spd_rdy)
  );

  fgsd_phase_cmp u_ph (
    .clk_i, .rst_ni, .in_win_i(ready_o), .fgh_rise_i(fgh_rise), .ref_i,
    .ph_chg_o(ph_chg), .ph_dis_o(ph_dis)
  );

  fgsd_lock_guard #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i, .rst_ni, .active_i(active), .ready_i(ready_o),
    .tick_i(lock_tick_i), .fault_o(fault)
  );

  assign ready_o      = spd_rdy & ~fault & active;
  assign lock_fault_o = fault;

  always_comb begin
    chg_o = 1'b0;
    dis_o = 1'b0;
    if (!active)         dis_o = 1'b1;
    else if (fault)      ;
    else if (!have_meas) chg_o = 1'b1;
    else begin
      chg_o = spd_chg | (ph_chg & ~spd_dis);
      dis_o = spd_dis | (ph_dis & ~spd_chg);
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chg_o && dis_o)); // R6
  AST_STOP_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i || brake_i |-> dis_o && !ready_o); // R7
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_fault_o && run_i && !brake_i |-> !chg_o && !dis_o && !ready_o); // R10
  AST_START_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !$past(active) |-> chg_o); // R8
endmodule

// File: tb/fg_speed_disc_bench.sv
module fg_speed_disc_bench;
  localparam int T_CNT = 1024;
  localparam int WIN   = 61;
  localparam int PW_MX = 255;

  logic clk = 1'b0;
  logic rst_ni, fg_i, ref_i, run_i, brake_i, lock_tick_i;
  logic chg_o, dis_o, ready_o, lock_fault_o;

  always #10 clk = ~clk;

  fg_speed_disc u_fg_speed_disc (
    .clk_i(clk), .rst_ni, .fg_i, .ref_i, .run_i, .brake_i, .lock_tick_i,
    .chg_o, .dis_o, .ready_o, .lock_fault_o
  );

  int n_chk = 0, n_fail = 0;
  int s_chg, s_dis, excl_bad = 0, rise_no = 0, prev_n;
  logic rdy_c1, rdy_end;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_w(input int n);
    int m;
    m = (n > T_CNT) ? n - T_CNT : T_CNT - n;
    return (m > PW_MX) ? PW_MX : m;
  endfunction

  function automatic int exp_rdy(input int n);
    return ((n >= T_CNT - WIN) && (n <= T_CNT + WIN)) ? 1 : 0;
  endfunction

  // ref_at: -1 none, -2 aligned with FG/2 rise, else cycle offset
  task automatic fg_period(input int n, input int ref_at);
    int ra;
    bit fgh;
    fgh = (rise_no % 2) == 0;
    ra = (ref_at == -2) ? (fgh ? 0 : -1) : ref_at;
    s_chg = 0; s_dis = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (chg_o) s_chg++;
      if (dis_o) s_dis++;
      if (chg_o && dis_o) excl_bad++;
      if (c == 1) rdy_c1 = ready_o;
      if (c == n - 1) rdy_end = ready_o;
      fg_i  = (c < n / 2);
      ref_i = (ra >= 0) && (c >= ra) && (c < ra + 4);
    end
    rise_no++;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) lock_tick_i = 1'b1;
      @(negedge clk) lock_tick_i = 1'b0;
    end
  endtask

  task automatic speed_step(input int n);
    fg_period(n, -2);
    chk("R2 chg width", s_chg, (prev_n > T_CNT) ? exp_w(prev_n) : 0);
    chk("R2 dis width", s_dis, (prev_n < T_CNT) ? exp_w(prev_n) : 0);
    chk("R3 ready", int'(rdy_c1), exp_rdy(prev_n));
    prev_n = n;
  endtask

  initial begin
    int dir_list[8] = '{1085, 1086, 963, 962, 1300, 700, 1024, 1050};
    void'($urandom(32'h5eed_0107));
    rst_ni = 1'b0; fg_i = 1'b0; ref_i = 1'b0; run_i = 1'b0;
    brake_i = 1'b0; lock_tick_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 reset dis", int'(dis_o), 1);
    chk("R7 reset chg", int'(chg_o), 0);
    chk("R7 reset ready", int'(ready_o), 0);
    chk("R10 reset fault", int'(lock_fault_o), 0);

    run_i = 1'b1;
    @(negedge clk);
    chk("R8 start chg", int'(chg_o), 1);
    fg_period(T_CNT, -2);
    chk("R1 R8 arm period chg", s_chg, T_CNT);
    fg_period(T_CNT, -2);
    chk("R8 chg ends at first capture", s_chg, 1);
    chk("R3 ready in window", int'(rdy_c1), 1);
    fg_period(T_CNT, -2);
    chk("R2 no pulse at target", s_chg + s_dis, 0);
    fg_period(T_CNT, -2);

    // FG/2 leads by 10
    fg_period(T_CNT, 10);
    chk("R4 fg lead dis", s_dis, 10);
    chk("R4 fg lead chg", s_chg, 0);
    // reference leads by 10
    fg_period(T_CNT, T_CNT - 10);
    begin
      int c1;
      c1 = s_chg;
      fg_period(T_CNT, -1);
      chk("R4 ref lead chg", c1 + s_chg, 10);
      chk("R4 ref lead dis", s_dis, 0);
    end
    // speed charge overrides phase discharge
    if (rise_no % 2 == 0) fg_period(T_CNT, -2);
    fg_period(1050, -2);
    fg_period(T_CNT, 10);
    chk("R6 speed wins chg", s_chg, 26);
    chk("R6 speed wins dis", s_dis, 0);
    fg_period(T_CNT, -2);
    // running count drops ready early
    fg_period(1200, -2);
    chk("R3 ready before long period", int'(rdy_c1), 1);
    chk("R3 ready drops early", int'(rdy_end), 0);
    // out of window: phase zeroed
    fg_period(1100, -2);
    if (rise_no % 2 == 1) fg_period(1100, -2);
    fg_period(1100, 10);
    chk("R5 phase ignored dis", s_dis, 0);
    chk("R5 speed chg", s_chg, exp_w(1100));
    prev_n = 1100;

    foreach (dir_list[i]) speed_step(dir_list[i]);
    for (int i = 0; i < 30; i++) speed_step(900 + int'($urandom_range(0, 250)));
    chk("R6 never both", excl_bad, 0);

    // lock protection
    repeat (1200) @(negedge clk);
    chk("R3 stalled ready", int'(ready_o), 0);
    ticks(31);
    chk("R9 no fault at 31", int'(lock_fault_o), 0);
    ticks(1);
    chk("R9 fault at 32", int'(lock_fault_o), 1);
    chk("R10 fault chg", int'(chg_o), 0);
    chk("R10 fault dis", int'(dis_o), 0);
    fg_period(T_CNT, -2); fg_period(T_CNT, -2);
    fg_period(T_CNT, -2);
    chk("R10 quiet with FG", s_chg + s_dis, 0);
    chk("R10 fault held", int'(lock_fault_o), 1);
    chk("R10 ready masked", int'(ready_o), 0);
    brake_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 brake clears fault", int'(lock_fault_o), 0);
    chk("R7 brake dis", int'(dis_o), 1);
    brake_i = 1'b0;
    rise_no = 0;
    @(negedge clk);
    chk("R8 restart chg", int'(chg_o), 1);

    fg_period(T_CNT, -2); fg_period(T_CNT, -2); fg_period(T_CNT, -2);
    chk("R3 ready again", int'(ready_o), 1);
    repeat (1200) @(negedge clk);
    ticks(20);
    fg_period(T_CNT, -2); fg_period(T_CNT, -2); fg_period(T_CNT, -2);
    chk("R3 ready recovered", int'(ready_o), 1);
    repeat (1200) @(negedge clk);
    ticks(20);
    chk("R9 ready clears count", int'(lock_fault_o), 0);
    ticks(12);
    chk("R9 fault after 32 fresh", int'(lock_fault_o), 1);
    run_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 stop clears fault", int'(lock_fault_o), 0);
    chk("R7 stop dis", int'(dis_o), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule